// File: doc/BRIEF.md
# Four-Channel DMA Bus Arbiter

This block decides which of four DMA channels owns the shared bus. Each channel raises a request line, and the arbiter issues a registered one-hot grant together with a grant-valid strobe. A 2-bit mode input selects the ranking. Three of the modes are fixed rankings. The fourth mode is a rotating ranking that moves on each time a transfer unit ends.

A grant holds until the owning channel pulses `unit_done_i`. Requests are therefore ranked again only at transfer-unit boundaries. On the same edge that a unit ends, the next winner can take over, so no idle cycle is inserted. A global enable must be high before any grant is issued. The address-error and NMI flags are sticky status bits that are kept outside the block. While either flag is high, no grant is issued and any grant already held is withdrawn.

Top module: `dma_prio_arb`

## Requirements
- R1: With mode 2'b00, an idle arbiter grants the requesting channel that ranks highest in the order 0, 1, 2, 3.
- R2: With mode 2'b01, an idle arbiter grants by the order 0, 2, 3, 1.
- R3: With mode 2'b10, an idle arbiter grants by the order 2, 0, 1, 3.
- R4: With mode 2'b11, the ranking starts at a base channel b and runs b, b+1, b+2, b+3 (mod 4). The base b is 0 after reset. When channel k's unit ends, the base becomes k+1 (mod 4).
- R5: While `enable_i` is low, `gnt_o` is all zeros one cycle later, and any held grant is dropped.
- R6: While `addr_err_i` or `nmi_i` is high, `gnt_o` is all zeros one cycle later, and any held grant is dropped.
- R7: A granted channel keeps its grant, whatever the requests or the mode do, until `unit_done_i` is sampled high.
- R8: The grant updates one clock after its inputs. `gnt_o` (bit i = channel i) has at most one bit set. `gnt_valid_o` equals the OR of `gnt_o`. With no requests pending, the grant goes to zero.
- R9: The rotation base changes only when `unit_done_i` is high while a grant is held. A done pulse with no grant has no effect. The base advances in every mode.
- R10: On the edge where a unit ends, the next grant is chosen from the current requests using the updated base, with no idle cycle in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 4 | Request, one bit per channel |
| mode_i | input | 2 | Ranking mode: 00, 01 and 10 are fixed rankings, 11 is rotating |
| enable_i | input | 1 | Master enable for all grants |
| addr_err_i | input | 1 | Sticky address-error flag; blocks grants |
| nmi_i | input | 1 | Sticky NMI flag; blocks grants |
| unit_done_i | input | 1 | Pulse from the granted channel when its transfer unit ends |
| gnt_o | output | 4 | One-hot grant |
| gnt_valid_o | output | 1 | A grant is active |

## Verification
The rotation base cannot be seen directly. It shows only in which channel wins a later contested arbitration, and it moves only on done pulses that arrive while a grant is held. The bench reaches it by running every request pattern in rotating mode one after another without reset, so the base has passed through all four values when each pattern is applied. It then applies long pseudo-random runs that mix done pulses with and without a held grant, mode changes, and toggles of the blocking inputs. A bench model tracks the base from the requirements alone.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  localparam int N_CH  = 4;
  localparam int IDX_W = $clog2(N_CH);

  typedef enum logic [1:0] {
    MODE_FIX_A  = 2'b00,
    MODE_FIX_B  = 2'b01,
    MODE_FIX_C  = 2'b10,
    MODE_ROTATE = 2'b11
  } arb_mode_e;

  typedef logic [IDX_W-1:0]            ch_idx_t;
  typedef logic [N_CH-1:0][IDX_W-1:0]  rank_t;
endpackage

// File: rtl/arb_rank_gen.sv
module arb_rank_gen
  import dma_arb_pkg::*;
(
  input  logic [1:0] mode_i,
  input  ch_idx_t    base_i,
  output rank_t      rank_o
);
  // entry 0 is highest rank
  localparam rank_t RANK_A = {2'd3, 2'd2, 2'd1, 2'd0};
  localparam rank_t RANK_B = {2'd1, 2'd3, 2'd2, 2'd0};
  localparam rank_t RANK_C = {2'd3, 2'd1, 2'd0, 2'd2};

  always_comb begin
    rank_o = RANK_A;
    unique case (mode_i)
      MODE_FIX_A: rank_o = RANK_A;
      MODE_FIX_B: rank_o = RANK_B;
      MODE_FIX_C: rank_o = RANK_C;
      default: begin
        for (int i = 0; i < N_CH; i++) rank_o[i] = base_i + ch_idx_t'(i);
      end
    endcase
  end
endmodule

// File: rtl/arb_pick.sv
module arb_pick
  import dma_arb_pkg::*;
(
  input  logic [N_CH-1:0] req_i,
  input  rank_t           rank_i,
  output logic [N_CH-1:0] win_o
);
  logic    found;
  ch_idx_t idx;

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = 0; i < N_CH; i++) begin
      if (!found && req_i[rank_i[i]]) begin
        found = 1'b1;
        idx   = rank_i[i];
      end
    end
    win_o = '0;
    if (found) win_o[idx] = 1'b1;
  end
endmodule

// File: rtl/arb_rot_state.sv
module arb_rot_state
  import dma_arb_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    adv_i,
  input  ch_idx_t served_i,
  output ch_idx_t base_nxt_o
);
  ch_idx_t base_q;

  assign base_nxt_o = adv_i ? served_i + ch_idx_t'(1) : base_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) base_q <= '0;
    else         base_q <= base_nxt_o;
  end
endmodule

// File: rtl/dma_prio_arb.sv
module dma_prio_arb
  import dma_arb_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_CH-1:0] req_i,
  input  logic [1:0]      mode_i,
  input  logic            enable_i,
  input  logic            addr_err_i,
  input  logic            nmi_i,
  input  logic            unit_done_i,
  output logic [N_CH-1:0] gnt_o,
  output logic            gnt_valid_o
);
  logic [N_CH-1:0] gnt_q, gnt_d, win;
  ch_idx_t         served, base_nxt;
  rank_t           rank;
  logic            blocked, busy, unit_end;

  assign busy     = |gnt_q;
  assign unit_end = busy & unit_done_i;
  assign blocked  = ~enable_i | addr_err_i | nmi_i;

  always_comb begin
    served = '0;
    for (int i = 0; i < N_CH; i++) if (gnt_q[i]) served = ch_idx_t'(i);
  end

  arb_rot_state u_rot (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .adv_i      (unit_end),
    .served_i   (served),
    .base_nxt_o (base_nxt)
  );

  arb_rank_gen u_rank (
    .mode_i (mode_i),
    .base_i (base_nxt),
    .rank_o (rank)
  );

  arb_pick u_pick (
    .req_i  (req_i),
    .rank_i (rank),
    .win_o  (win)
  );

  always_comb begin
    if (blocked)                   gnt_d = '0;
    else if (busy && !unit_done_i) gnt_d = gnt_q;
    else                           gnt_d = win;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gnt_q <= '0;
    else         gnt_q <= gnt_d;
  end

  assign gnt_o       = gnt_q;
  assign gnt_valid_o = busy;
endmodule

// File: rtl/dma_prio_arb_chk.sv
module dma_prio_arb_chk
  import dma_arb_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic [N_CH-1:0] req_i,
  input logic            enable_i,
  input logic            addr_err_i,
  input logic            nmi_i,
  input logic            unit_done_i,
  input logic [N_CH-1:0] gnt_o,
  input logic            gnt_valid_o
);
  a_r8_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));

  a_r5_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> !gnt_valid_o);

  a_r6_flags_block: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_err_i || nmi_i) |=> gnt_o == '0);

  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_valid_o && !unit_done_i && enable_i && !addr_err_i && !nmi_i)
      |=> $stable(gnt_o));

  a_r8_new_grant_requested: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!gnt_valid_o || unit_done_i) |=> (gnt_o == '0) || ((gnt_o & $past(req_i)) != '0));
endmodule

bind dma_prio_arb dma_prio_arb_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .enable_i    (enable_i),
  .addr_err_i  (addr_err_i),
  .nmi_i       (nmi_i),
  .unit_done_i (unit_done_i),
  .gnt_o       (gnt_o),
  .gnt_valid_o (gnt_valid_o)
);

// File: tb/sim_dma_prio_arb.sv
module sim_dma_prio_arb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] req_i = '0;
  logic [1:0] mode_i = '0;
  logic       enable_i = 1'b0, addr_err_i = 1'b0, nmi_i = 1'b0, unit_done_i = 1'b0;
  logic [3:0] gnt_o;
  logic       gnt_valid_o;

  int n_vec = 0, n_bad = 0;
  bit finished = 0;
  logic [3:0] m_gnt = '0;
  logic [1:0] m_base = '0;

  always #5 clk_i = ~clk_i;

  dma_prio_arb u0 (.*);

  function automatic logic [1:0] rank_at(input logic [1:0] mode, input logic [1:0] base, input int pos);
    case (mode)
      2'b00: return 2'(pos);
      2'b01: return (pos == 0) ? 2'd0 : (pos == 1) ? 2'd2 : (pos == 2) ? 2'd3 : 2'd1;
      2'b10: return (pos == 0) ? 2'd2 : (pos == 1) ? 2'd0 : (pos == 2) ? 2'd1 : 2'd3;
      default: return 2'((int'(base) + pos) % 4);
    endcase
  endfunction

  task automatic check(input logic [3:0] exp, input string tag);
    n_vec++;
    if (gnt_o !== exp || gnt_valid_o !== (|exp)) begin
      n_bad++;
      $display("FAIL %s: gnt=%b valid=%b expected gnt=%b valid=%b", tag, gnt_o, gnt_valid_o, exp, |exp);
    end
  endtask

  task automatic step(input logic [3:0] req, input logic done, input logic en,
                      input logic err, input logic nmi, input logic [1:0] mode, input string tag);
    logic [3:0] ng, cand;
    logic [1:0] nb, srv;
    bit blk, hit;
    req_i = req; unit_done_i = done; enable_i = en; addr_err_i = err; nmi_i = nmi; mode_i = mode;
    blk = !en || err || nmi;
    srv = '0;
    for (int i = 0; i < 4; i++) if (m_gnt[i]) srv = 2'(i);
    nb = (|m_gnt && done) ? srv + 2'd1 : m_base;
    cand = '0; hit = 0;
    for (int p = 0; p < 4; p++) begin
      logic [1:0] c;
      c = rank_at(mode, nb, p);
      if (!hit && req[c]) begin hit = 1; cand[c] = 1'b1; end
    end
    if (blk) ng = '0;
    else if (|m_gnt && !done) ng = m_gnt;
    else ng = cand;
    @(posedge clk_i);
    @(negedge clk_i);
    m_gnt = ng; m_base = nb;
    check(ng, tag);
  endtask

  initial begin
    int cnt = 0;
    while (!finished && cnt < 150000) begin @(posedge clk_i); cnt++; end
    if (!finished) begin
      n_bad++; n_vec++;
      $display("FAIL watchdog: run did not complete");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    #12;
    check(4'b0000, "R8 reset");
    @(negedge clk_i); rst_ni = 1'b1;
    check(4'b0000, "R8 after reset");

    // R1 R2 R3: every request pattern from idle
    for (int m = 0; m < 3; m++) begin
      for (int r = 1; r < 16; r++) begin
        step(4'(r), 0, 1, 0, 0, 2'(m), m == 0 ? "R1" : m == 1 ? "R2" : "R3");
        step(4'b0000, 1, 1, 0, 0, 2'(m), "R8 release");
      end
    end

    // R4: rotating mode, base carried across patterns
    for (int k = 0; k < 2; k++)
      for (int r = 1; r < 16; r++) begin
        step(4'(r), 0, 1, 0, 0, 2'b11, "R4");
        step(4'(r), 1, 1, 0, 0, 2'b11, "R10 back-to-back");
        step(4'b0000, 1, 1, 0, 0, 2'b11, "R8 idle");
      end

    // R9: done pulses without a grant leave the base alone
    step(4'b0000, 1, 1, 0, 0, 2'b11, "R9");
    step(4'b0000, 1, 1, 0, 0, 2'b11, "R9");
    step(4'b1111, 0, 1, 0, 0, 2'b11, "R9 base unchanged");
    step(4'b1111, 1, 1, 0, 0, 2'b00, "R9 advance in fixed mode");
    step(4'b0000, 1, 1, 0, 0, 2'b00, "R9");
    step(4'b1111, 0, 1, 0, 0, 2'b11, "R9 base moved");
    step(4'b0000, 1, 1, 0, 0, 2'b11, "R9");

    // R7: hold while others request and mode changes
    step(4'b1000, 0, 1, 0, 0, 2'b00, "R7");
    for (int i = 0; i < 4; i++) step(4'b0111, 0, 1, 0, 0, 2'(i), "R7 hold");
    step(4'b0111, 1, 1, 0, 0, 2'b00, "R7 release to next");

    // R5: enable low drops grant and blocks new ones
    step(4'b1111, 0, 0, 0, 0, 2'b00, "R5 drop");
    step(4'b1111, 0, 0, 0, 0, 2'b00, "R5 blocked");
    step(4'b1111, 0, 1, 0, 0, 2'b10, "R3 after enable");

    // R6: each flag alone
    step(4'b1111, 0, 1, 1, 0, 2'b10, "R6 addr err");
    step(4'b1111, 0, 1, 1, 0, 2'b10, "R6 addr err");
    step(4'b1111, 0, 1, 0, 0, 2'b01, "R2 regrant");
    step(4'b1111, 0, 1, 0, 1, 2'b01, "R6 nmi");
    step(4'b1111, 0, 1, 0, 1, 2'b01, "R6 nmi");

    // mixed pseudo-random run
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] v;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      v = lfsr;
      step(v[3:0], v[4] & v[5] | v[6], v[7] | v[8] | v[9], v[10] & v[11] & v[12],
           v[13] & v[14] & v[15], (i % 300 < 150) ? 2'b11 : v[9:8], "R8 mixed");
    end

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule